// File: doc/BRIEF.md
# Cross-Domain CPU Event Pulse Generator

This block carries CPU wake-up events from an interrupt controller running on the bus clock into the CPU clock domain. Each source line delivers a one-cycle strobe on the bus clock. The strobes of lines whose event-enable bit is set are merged by OR into a single request. That request sets a level flag in the bus domain. The flag stays high until the CPU side has acted on it.

On the CPU side the level passes through a flop synchronizer running on the free-running CPU clock. A rising-edge detector then turns it into a pulse one CPU cycle wide. At the same moment the CPU side raises a clear signal, synchronous to its own clock. The clear resets the bus-domain level asynchronously. It stays high until the synchronized copy of the level has gone low, which closes the handshake. The same lines also carry an interrupt-enable bit that controls a per-line pending flag. Event-only traffic leaves that flag untouched.

Top module: `evg_event_bridge`

## Requirements
- R1: A strobe on any line whose `ev_mask` bit is 1 sets `evt_req` at the next bus clock edge. Strobes on several lines in the same cycle produce one request.
- R2: Once set, `evt_req` stays high, whatever the strobe inputs do, until `evt_clr` is asserted.
- R3: Each assertion of `evt_req` produces exactly one `cpu_event` pulse, one CPU clock cycle wide. It appears at the third CPU clock edge after the level rises, with the default two synchronizer stages.
- R4: `evt_clr` is high in the cycle of the pulse. It clears `evt_req` without waiting for a bus clock edge. It stays high until the synchronized level has been seen low, and then returns low.
- R5: Strobes that arrive while `evt_req` is high, or while `evt_clr` is high, produce no additional pulse.
- R6: A strobe that arrives after the handshake has completed (both `evt_req` and `evt_clr` low) produces a new pulse.
- R7: A strobe on a line whose `ev_mask` bit is 0 produces neither a request nor a pulse.
- R8: Bit i of `pend` is set by a strobe on line i only when `irq_mask` bit i is 1, regardless of `ev_mask`. A strobe with `ev_mask`=1 and `irq_mask`=0 leaves `pend` unchanged.
- R9: A 1 on bit i of `pend_clr` clears `pend` bit i at the next bus edge. A strobe on line i with `irq_mask` bit i set in that same cycle keeps the bit set.
- R10: While either reset is low, its domain's outputs are 0. After reset, `evt_req`, `evt_clr`, `cpu_event` and `pend` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus / controller clock |
| bus_rst_n | input | 1 | Active-low bus-domain reset, released synchronously |
| ev_strobe | input | NUM_LINES | One-cycle detected-event strobes, one per line |
| ev_mask | input | NUM_LINES | Per-line CPU event enable |
| irq_mask | input | NUM_LINES | Per-line interrupt enable for the pending flags |
| pend_clr | input | NUM_LINES | Per-line pending clear strobe |
| pend | output | NUM_LINES | Per-line interrupt pending flags |
| evt_req | output | 1 | Level event request in the bus domain |
| cpu_clk | input | 1 | Free-running CPU clock |
| cpu_rst_n | input | 1 | Active-low CPU-domain reset, released synchronously |
| cpu_event | output | 1 | One-cycle event pulse on the CPU clock |
| evt_clr | output | 1 | Clear returned to the bus domain, synchronous to the CPU clock |

## Verification
Suppose the synchronizer or edge register holds a wrong value. The result shows at `cpu_event` as a missing pulse, a doubled pulse or a pulse two cycles wide, within three CPU cycles of the level change. If the clear handshake stalls, `evt_req` or `evt_clr` stays high, and the next masked-in strobe then produces no pulse. This is visible within a few tens of bus cycles. A wrong gating term in the pending logic shows as a `pend` bit that differs from the mask-derived value at the first bus edge after a strobe.

// File: rtl/evg_pkg.sv
package evg_pkg;
  localparam int unsigned EVG_DEF_LINES = 4;
  localparam int unsigned EVG_DEF_SYNC  = 2;
  localparam int unsigned EVG_MIN_SYNC  = 2;
endpackage

// File: rtl/evg_req_combine.sv
module evg_req_combine #(
  parameter int unsigned NUM_LINES = evg_pkg::EVG_DEF_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] strobe_i,
  input  logic [NUM_LINES-1:0] ev_mask_i,
  input  logic [NUM_LINES-1:0] irq_mask_i,
  input  logic [NUM_LINES-1:0] pend_clr_i,
  output logic                 req_o,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] pend_d;

  // merged event request: any enabled line
  always_comb begin
    req_o = |(strobe_i & ev_mask_i);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic set_irq;
    always_comb begin
      set_irq   = strobe_i[g] & irq_mask_i[g];
      pend_d[g] = set_irq | (pend_q[g] & ~pend_clr_i[g]);
    end

    // R8: no pending bit appears without an interrupt-enabled strobe
    a_r8_no_event_only_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[g] && !(strobe_i[g] && irq_mask_i[g])) |=> !pend_q[g]);
    // R9: a clear without a same-cycle set empties the bit
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr_i[g] && !(strobe_i[g] && irq_mask_i[g])) |=> !pend_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/evg_level_latch.sv
module evg_level_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic level_o
);
  logic level_q;
  logic level_d;
  logic hold_rst_n;

  // bus reset or the CPU-side clear empties the flag at once
  always_comb begin
    hold_rst_n = rst_n & ~clr_i;
    level_d    = level_q | set_i;
  end

  always_ff @(posedge clk or negedge hold_rst_n) begin
    if (!hold_rst_n) level_q <= 1'b0;
    else             level_q <= level_d;
  end

  // R1/R2: a set or held level survives the next edge unless clear intervened
  a_r2_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_q || set_i) && !clr_i) |=> (level_q || clr_i));

  assign level_o = level_q;
endmodule

// File: rtl/evg_cpu_pulse.sv
module evg_cpu_pulse #(
  parameter int unsigned SYNC_STAGES = evg_pkg::EVG_DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o,
  output logic clr_o
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   seen_q, seen_d;
  logic                   pulse_q, pulse_d;
  logic                   clr_q, clr_d;

  if (SYNC_STAGES < evg_pkg::EVG_MIN_SYNC) begin : g_bad_cfg
    initial $error("evg_cpu_pulse: SYNC_STAGES below minimum");
  end

  always_comb begin
    sync_d  = {sync_q[TOP-1:0], level_i};
    seen_d  = sync_q[TOP];
    pulse_d = sync_q[TOP] & ~seen_q;
    clr_d   = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      seen_q  <= seen_d;
      pulse_q <= pulse_d;
      clr_q   <= clr_d;
    end
  end

  // R3: pulse never lasts two cycles
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R4: clear is raised together with the pulse
  a_r4_clr_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> clr_q);

  assign pulse_o = pulse_q;
  assign clr_o   = clr_q;
endmodule

// File: rtl/evg_event_bridge.sv
module evg_event_bridge #(
  parameter int unsigned NUM_LINES   = evg_pkg::EVG_DEF_LINES,
  parameter int unsigned SYNC_STAGES = evg_pkg::EVG_DEF_SYNC
) (
  input  logic                 bus_clk,
  input  logic                 bus_rst_n,
  input  logic [NUM_LINES-1:0] ev_strobe,
  input  logic [NUM_LINES-1:0] ev_mask,
  input  logic [NUM_LINES-1:0] irq_mask,
  input  logic [NUM_LINES-1:0] pend_clr,
  output logic [NUM_LINES-1:0] pend,
  output logic                 evt_req,
  input  logic                 cpu_clk,
  input  logic                 cpu_rst_n,
  output logic                 cpu_event,
  output logic                 evt_clr
);
  logic any_req;
  logic level;
  logic clr;

  evg_req_combine #(.NUM_LINES(NUM_LINES)) i_combine (
    .clk       (bus_clk),
    .rst_n     (bus_rst_n),
    .strobe_i  (ev_strobe),
    .ev_mask_i (ev_mask),
    .irq_mask_i(irq_mask),
    .pend_clr_i(pend_clr),
    .req_o     (any_req),
    .pend_o    (pend)
  );

  evg_level_latch i_latch (
    .clk    (bus_clk),
    .rst_n  (bus_rst_n),
    .set_i  (any_req),
    .clr_i  (clr),
    .level_o(level)
  );

  evg_cpu_pulse #(.SYNC_STAGES(SYNC_STAGES)) i_pulse (
    .clk    (cpu_clk),
    .rst_n  (cpu_rst_n),
    .level_i(level),
    .pulse_o(cpu_event),
    .clr_o  (clr)
  );

  assign evt_req = level;
  assign evt_clr = clr;
endmodule

// File: tb/test_evg_event_bridge.sv
module test_evg_event_bridge;
  localparam int N = 4;

  logic         bus_clk = 1'b0;
  logic         cpu_clk = 1'b0;
  logic         bus_rst_n, cpu_rst_n;
  logic [N-1:0] ev_strobe, ev_mask, irq_mask, pend_clr;
  logic [N-1:0] pend;
  logic         evt_req, cpu_event, evt_clr;

  always #5 bus_clk = ~bus_clk;
  always #7 cpu_clk = ~cpu_clk;

  evg_event_bridge #(.NUM_LINES(N), .SYNC_STAGES(2)) i_evg_event_bridge (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .ev_strobe(ev_strobe),
    .ev_mask(ev_mask), .irq_mask(irq_mask), .pend_clr(pend_clr),
    .pend(pend), .evt_req(evt_req), .cpu_clk(cpu_clk),
    .cpu_rst_n(cpu_rst_n), .cpu_event(cpu_event), .evt_clr(evt_clr)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int pulses = 0;
  logic prev_ev = 1'b0;

  // {strobe, ev_mask, irq_mask, expected pulses, expected pend}
  localparam logic [19:0] VEC [6] = '{
    {4'b0001, 4'b0001, 4'b0000, 4'd1, 4'b0000},  // R1 R8 event only
    {4'b0010, 4'b0001, 4'b0000, 4'd0, 4'b0000},  // R7 masked line
    {4'b0110, 4'b0100, 4'b0010, 4'd1, 4'b0010},  // R1 R8 mixed
    {4'b1111, 4'b1111, 4'b1111, 4'd1, 4'b1111},  // R1 merge of lines
    {4'b1000, 4'b0000, 4'b1000, 4'd0, 4'b1000},  // R7 R8 interrupt only
    {4'b0000, 4'b1111, 4'b1111, 4'd0, 4'b0000}   // R7 no strobe
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R3 pulse width and count monitor
  always @(negedge cpu_clk) begin
    if (cpu_event) begin
      if (prev_ev) chk(1'b0, "R3 pulse wider than one cycle", 2, 1);
      else pulses++;
    end
    prev_ev = cpu_event;
  end

  task automatic strobe_once(input logic [N-1:0] s);
    @(negedge bus_clk) ev_strobe = s;
    @(negedge bus_clk) ev_strobe = '0;
  endtask

  task automatic settle();
    repeat (25) @(negedge bus_clk);
  endtask

  task automatic clear_pend();
    @(negedge bus_clk) pend_clr = '1;
    @(negedge bus_clk) pend_clr = '0;
  endtask

  initial begin
    #100000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    bus_rst_n = 1'b0; cpu_rst_n = 1'b0;
    ev_strobe = '0; ev_mask = '0; irq_mask = '0; pend_clr = '0;
    repeat (5) @(negedge bus_clk);
    chk(evt_req == 1'b0 && evt_clr == 1'b0 && cpu_event == 1'b0 && pend == '0,
        "R10 outputs low in reset", int'({evt_req, evt_clr, cpu_event}), 0);
    bus_rst_n = 1'b1;
    @(negedge cpu_clk) cpu_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    chk(evt_req == 1'b0 && evt_clr == 1'b0 && pend == '0 && pulses == 0,
        "R10 idle after reset", pulses, 0);

    // vector table
    foreach (VEC[i]) begin
      ev_mask  = VEC[i][15:12];
      irq_mask = VEC[i][11:8];
      base = pulses;
      strobe_once(VEC[i][19:16]);
      settle();
      chk(pulses - base == int'(VEC[i][7:4]), "R1 R3 R7 pulse count",
          pulses - base, int'(VEC[i][7:4]));
      chk(pend == VEC[i][3:0], "R8 pending flags", int'(pend), int'(VEC[i][3:0]));
      chk(evt_req == 1'b0 && evt_clr == 1'b0, "R4 handshake closed",
          int'({evt_req, evt_clr}), 0);
      clear_pend();
    end

    // R1 R2: level sets on next bus edge and holds before clear
    ev_mask = 4'b0100; irq_mask = '0;
    base = pulses;
    @(negedge bus_clk) ev_strobe = 4'b0100;
    @(negedge bus_clk) ev_strobe = '0;
    chk(evt_req == 1'b1, "R1 level set after one bus edge", int'(evt_req), 1);
    chk(evt_clr == 1'b0, "R2 level held, no clear yet", int'(evt_clr), 0);
    // R3 latency: pulse within four CPU cycles
    repeat (4) @(negedge cpu_clk);
    chk(pulses - base == 1, "R3 pulse within latency", pulses - base, 1);
    settle();
    chk(evt_req == 1'b0 && evt_clr == 1'b0, "R4 level cleared and clear released",
        int'({evt_req, evt_clr}), 0);

    // R5: back-to-back strobes merge into one pulse
    base = pulses;
    @(negedge bus_clk) ev_strobe = 4'b0100;
    @(negedge bus_clk) ev_strobe = 4'b0100;
    @(negedge bus_clk) ev_strobe = 4'b0100;
    @(negedge bus_clk) ev_strobe = '0;
    settle();
    chk(pulses - base == 1, "R5 merged strobes one pulse", pulses - base, 1);

    // R6: a later event gives a fresh pulse
    strobe_once(4'b0100);
    settle();
    chk(pulses - base == 2, "R6 new pulse after handshake", pulses - base, 2);

    // R9: clear with simultaneous set keeps the bit; lone clear empties it
    ev_mask = '0; irq_mask = 4'b0001;
    strobe_once(4'b0001);
    chk(pend == 4'b0001, "R8 pend set by interrupt-enabled strobe", int'(pend), 1);
    @(negedge bus_clk) begin ev_strobe = 4'b0001; pend_clr = 4'b0001; end
    @(negedge bus_clk) begin ev_strobe = '0; pend_clr = '0; end
    chk(pend == 4'b0001, "R9 set wins over clear", int'(pend), 1);
    @(negedge bus_clk) pend_clr = 4'b0001;
    @(negedge bus_clk) pend_clr = '0;
    chk(pend == 4'b0000, "R9 clear empties pend", int'(pend), 0);
    settle();
    chk(pulses - base == 2, "R7 irq-only strobes give no pulse", pulses - base, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule